// File: doc/BRIEF.md
# Linked-descriptor DMA channel controller

This block sequences a single DMA channel through a chain of transfer descriptors kept in memory. Each descriptor is four 32-bit words on a 32-byte boundary: byte count, source address, destination address and a link word. The link word points at the next descriptor. Its low bits carry per-link flags: end of chain, raise an end-of-segment event when this link finishes, and fetch the next descriptor as snoopable. The pointer is masked to the 32-byte boundary before it is used.

Software writes the first link word into the current-link register and then sets the go bit in the control register. The controller reads the four words through a simple request/acknowledge memory port. It hands count, source and destination to an external data mover with a one-cycle launch pulse, and waits for the mover to report done or error. After done, it either follows the link word or stops when the link is marked end of chain.

Events are kept in a status register whose event bits software clears by writing 1. Busy and halted are live bits in the same register. An abort stops the walk and sets halted. A control write of all zeros returns the channel to its reset condition. The channel can instead be armed to wait for an external start pin.

Top module: `ldma_chan`

## Requirements
- R1: After reset the status (address 1), control (address 0) and current-link (address 2) registers read 0, and `irq`, `mem_req` and `mv_go` are low.
- R2: A descriptor is read as four words at the link base (link word with bits 4:0 cleared) plus 0, 4, 8 and 12, in the order count, source, destination, link word.
- R3: `mv_go` pulses for one cycle only after the fourth word is accepted and never together with `mem_req`. While it is high, `mv_count`, `mv_src` and `mv_dst` carry that descriptor's first three words.
- R4: When `mv_done` arrives for a link whose link word has bit 0 clear, the current-link register takes that link word and the next descriptor is fetched from its masked base. The next-link register (address 3) shows the link word of the descriptor last fetched. `mem_snoop` equals bit 2 of the current-link register.
- R5: When `mv_done` arrives for a link whose link word has bit 0 set, the walk stops, status bit 2 (end of chain) is set and status bit 3 (busy) clears.
- R6: When `mv_done` arrives for a link whose link word has bit 1 set, status bit 1 (end of segment) is set.
- R7: `mv_err` during a transfer sets status bit 0 (error) and bit 4 (halted), clears busy and stops all further fetches. Busy and halted are never both set.
- R8: Writing the status register clears each of bits 2:0 that is written as 1 and leaves the others. Bits 3 and 4 cannot be changed this way.
- R9: A control write with bit 1 (abort) set while busy clears busy, sets halted, and causes no further `mv_go`.
- R10: A control write with bit 0 (go) and bit 2 (external start) set makes the channel busy but keeps `mem_req` low until `ext_start` is seen high.
- R11: A control write of zero clears the control bits, the event bits and halted, and leaves the channel idle.
- R12: `irq` is high when status bit 0 is set with control bit 3, when status bit 1 is set with control bit 4, or when status bit 2 is set with control bit 5.
- R13: Writes to the current-link register are ignored while the channel is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 current link, 3 next link |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read data of the selected register |
| ext_start | input | 1 | External start pin |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_snoop | output | 1 | Fetch is snoopable |
| mem_ack | input | 1 | Read data valid, word accepted |
| mem_rdata | input | 32 | Read data |
| mv_go | output | 1 | One-cycle launch of the data mover |
| mv_count | output | 32 | Byte count for the mover |
| mv_src | output | 32 | Source address for the mover |
| mv_dst | output | 32 | Destination address for the mover |
| mv_done | input | 1 | Mover finished the current transfer |
| mv_err | input | 1 | Mover failed the current transfer |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `mem_ack` comes only while `mem_req` is high, at most once per requested word, and that the mover answers each launch with a single pulse on exactly one of `mv_done` or `mv_err`. They also assume the host makes at most one register write per cycle. The memory and mover models in the bench answer on the falling edge, so they keep to these rules. The one exception is the abort case: there the mover's late done pulse is allowed to arrive while the channel is idle, to show that it is ignored.

// File: rtl/ldma_pkg.sv
package ldma_pkg;
    localparam int WORD_W     = 32;
    localparam int DESC_WORDS = 4;
    localparam int IDX_W      = $clog2(DESC_WORDS);
    localparam int ALIGN_LSB  = 5;
    localparam int MODE_W     = 6;

    // descriptor word positions
    localparam int D_COUNT = 0;
    localparam int D_SRC   = 1;
    localparam int D_DST   = 2;
    localparam int D_LINK  = 3;

    // control bits
    localparam int M_GO     = 0;
    localparam int M_ABORT  = 1;
    localparam int M_EXT    = 2;
    localparam int M_ERR_IE = 3;
    localparam int M_SEG_IE = 4;
    localparam int M_EOL_IE = 5;

    // status bits
    localparam int S_ERR  = 0;
    localparam int S_SEG  = 1;
    localparam int S_EOL  = 2;
    localparam int S_BUSY = 3;
    localparam int S_HALT = 4;

    // link word flag bits
    localparam int L_EOL   = 0;
    localparam int L_SEG   = 1;
    localparam int L_SNOOP = 2;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_CUR  = 2'd2,
        REG_NEXT = 2'd3
    } ldma_reg_e;

    typedef enum logic [2:0] {
        W_IDLE, W_WAIT, W_FETCH, W_ISSUE, W_XFER
    } walk_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] link;
        logic [WORD_W-1:0] dst;
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] count;
    } ldma_desc_t;

    typedef struct packed {
        logic err;
        logic seg;
        logic eol;
    } ldma_evt_t;

    function automatic logic [WORD_W-1:0] link_base(input logic [WORD_W-1:0] w);
        return {w[WORD_W-1:ALIGN_LSB], {ALIGN_LSB{1'b0}}};
    endfunction
endpackage

// File: rtl/ldma_walker.sv
module ldma_walker
    import ldma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              launch_ext,
    input  logic              abort,
    input  logic              chan_reset,
    input  logic              ext_start,
    input  logic              cur_we,
    input  logic [WORD_W-1:0] cur_wdata,
    output logic              busy,
    output ldma_evt_t         evt,
    output logic [WORD_W-1:0] cur_link,
    output logic [WORD_W-1:0] next_link,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    output logic              mem_snoop,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mv_go,
    output logic [WORD_W-1:0] mv_count,
    output logic [WORD_W-1:0] mv_src,
    output logic [WORD_W-1:0] mv_dst,
    input  logic              mv_done,
    input  logic              mv_err
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

    walk_state_e       state;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] dw [DESC_WORDS];
    ldma_desc_t        desc;
    logic              stop;
    logic              xfer_end;

    assign stop     = abort | chan_reset;
    assign xfer_end = (state == W_XFER) & ~stop;

    // one capture register per descriptor word
    for (genvar gi = 0; gi < DESC_WORDS; gi++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                dw[gi] <= '0;
            else if (state == W_FETCH && mem_ack && !stop && idx == IDX_W'(gi))
                dw[gi] <= mem_rdata;
        end
    end

    assign desc = '{link: dw[D_LINK], dst: dw[D_DST], src: dw[D_SRC], count: dw[D_COUNT]};

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= W_IDLE;
            idx      <= '0;
            cur_link <= '0;
        end else if (stop) begin
            state <= W_IDLE;
            idx   <= '0;
        end else begin
            unique case (state)
                W_IDLE: begin
                    if (launch) begin
                        state <= launch_ext ? W_WAIT : W_FETCH;
                        idx   <= '0;
                    end else if (cur_we) begin
                        cur_link <= cur_wdata;
                    end
                end
                W_WAIT:  if (ext_start) state <= W_FETCH;
                W_FETCH: begin
                    if (mem_ack) begin
                        if (idx == LAST_IDX) begin
                            state <= W_ISSUE;
                            idx   <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                W_ISSUE: state <= W_XFER;
                W_XFER: begin
                    if (mv_err) begin
                        state <= W_IDLE;
                    end else if (mv_done) begin
                        if (desc.link[L_EOL]) begin
                            state <= W_IDLE;
                        end else begin
                            cur_link <= desc.link;
                            state    <= W_FETCH;
                        end
                    end
                end
                default: state <= W_IDLE;
            endcase
        end
    end

    assign busy      = (state != W_IDLE);
    assign mem_req   = (state == W_FETCH);
    assign mem_addr  = link_base(cur_link) + {{(WORD_W-IDX_W-2){1'b0}}, idx, 2'b00};
    assign mem_snoop = cur_link[L_SNOOP];
    assign mv_go     = (state == W_ISSUE);
    assign mv_count  = desc.count;
    assign mv_src    = desc.src;
    assign mv_dst    = desc.dst;
    assign next_link = desc.link;

    assign evt.err = xfer_end & mv_err;
    assign evt.seg = xfer_end & ~mv_err & mv_done & desc.link[L_SEG];
    assign evt.eol = xfer_end & ~mv_err & mv_done & desc.link[L_EOL];

    assert_fetch_step_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && !stop) |=> (mem_req ? (mem_addr == $past(mem_addr) + 4) : mv_go))
        else $error("fetch address did not step by one word");

    assert_go_after_fetch_R3: assert property (@(posedge clk) disable iff (rst)
        mv_go |-> ($past(mem_ack) && !mem_req))
        else $error("mover launched without a completed fetch");

    assert_go_single_R3: assert property (@(posedge clk) disable iff (rst)
        mv_go |=> !mv_go)
        else $error("mover launch longer than one cycle");

    assert_err_stops_R7: assert property (@(posedge clk) disable iff (rst)
        (state == W_XFER && mv_err && !stop) |=> (!busy && !mem_req))
        else $error("channel kept running after mover error");
endmodule

// File: rtl/ldma_regs.sv
module ldma_regs
    import ldma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              busy,
    input  ldma_evt_t         evt,
    input  logic [WORD_W-1:0] cur_link,
    input  logic [WORD_W-1:0] next_link,
    output logic              launch,
    output logic              launch_ext,
    output logic              abort,
    output logic              chan_reset,
    output logic              cur_we,
    output logic              irq
);
    localparam logic [MODE_W-1:0] ACTION_MASK = MODE_W'((1 << M_GO) | (1 << M_ABORT));

    ldma_reg_e         sel;
    logic [MODE_W-1:0] ctrl_q;
    ldma_evt_t         ev_q;
    ldma_evt_t         clr;
    logic              halted_q;
    logic              wr_ctrl;
    logic              wr_stat;

    assign sel     = ldma_reg_e'(reg_addr);
    assign wr_ctrl = reg_we & (sel == REG_CTRL);
    assign wr_stat = reg_we & (sel == REG_STAT);

    assign chan_reset = wr_ctrl & (reg_wdata == '0);
    assign launch     = wr_ctrl & reg_wdata[M_GO] & ~reg_wdata[M_ABORT] & ~busy;
    assign launch_ext = reg_wdata[M_EXT];
    assign abort      = wr_ctrl & reg_wdata[M_ABORT] & busy;
    assign cur_we     = reg_we & (sel == REG_CUR) & ~busy;

    assign clr.err = wr_stat & reg_wdata[S_ERR];
    assign clr.seg = wr_stat & reg_wdata[S_SEG];
    assign clr.eol = wr_stat & reg_wdata[S_EOL];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            ev_q     <= '0;
            halted_q <= 1'b0;
        end else begin
            if (wr_ctrl)
                ctrl_q <= reg_wdata[MODE_W-1:0] & ~ACTION_MASK;
            if (chan_reset)
                ev_q <= '0;
            else
                ev_q <= (ev_q & ~clr) | evt;
            if (chan_reset || launch)
                halted_q <= 1'b0;
            else if (abort || evt.err)
                halted_q <= 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            REG_CTRL: reg_rdata[MODE_W-1:0] = ctrl_q;
            REG_STAT: begin
                reg_rdata[S_ERR]  = ev_q.err;
                reg_rdata[S_SEG]  = ev_q.seg;
                reg_rdata[S_EOL]  = ev_q.eol;
                reg_rdata[S_BUSY] = busy;
                reg_rdata[S_HALT] = halted_q;
            end
            REG_CUR:  reg_rdata = cur_link;
            REG_NEXT: reg_rdata = next_link;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = (ev_q.err & ctrl_q[M_ERR_IE]) |
                 (ev_q.seg & ctrl_q[M_SEG_IE]) |
                 (ev_q.eol & ctrl_q[M_EOL_IE]);

    assert_halt_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !(busy && halted_q))
        else $error("busy and halted both set");

    assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && reg_wdata[S_ERR] && !evt.err) |=> !ev_q.err)
        else $error("error bit survived a write-one clear");

    assert_abort_halts_R9: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!busy && halted_q))
        else $error("abort did not halt the channel");

    assert_zero_ctrl_R11: assert property (@(posedge clk) disable iff (rst)
        chan_reset |=> (!busy && !irq && !halted_q))
        else $error("zero control write did not reset the channel");
endmodule

// File: rtl/ldma_chan.sv
module ldma_chan
    import ldma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              ext_start,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    output logic              mem_snoop,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mv_go,
    output logic [WORD_W-1:0] mv_count,
    output logic [WORD_W-1:0] mv_src,
    output logic [WORD_W-1:0] mv_dst,
    input  logic              mv_done,
    input  logic              mv_err,
    output logic              irq
);
    logic              busy;
    ldma_evt_t         evt;
    logic [WORD_W-1:0] cur_link;
    logic [WORD_W-1:0] next_link;
    logic              launch;
    logic              launch_ext;
    logic              abort;
    logic              chan_reset;
    logic              cur_we;

    ldma_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy       (busy),
        .evt        (evt),
        .cur_link   (cur_link),
        .next_link  (next_link),
        .launch     (launch),
        .launch_ext (launch_ext),
        .abort      (abort),
        .chan_reset (chan_reset),
        .cur_we     (cur_we),
        .irq        (irq)
    );

    ldma_walker u_walker (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .launch_ext (launch_ext),
        .abort      (abort),
        .chan_reset (chan_reset),
        .ext_start  (ext_start),
        .cur_we     (cur_we),
        .cur_wdata  (reg_wdata),
        .busy       (busy),
        .evt        (evt),
        .cur_link   (cur_link),
        .next_link  (next_link),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_snoop  (mem_snoop),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .mv_go      (mv_go),
        .mv_count   (mv_count),
        .mv_src     (mv_src),
        .mv_dst     (mv_dst),
        .mv_done    (mv_done),
        .mv_err     (mv_err)
    );
endmodule

// File: tb/ldma_chan_bench.sv
module ldma_chan_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ext_start = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_snoop;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mv_go;
    logic [31:0] mv_count, mv_src, mv_dst;
    logic        mv_done = 1'b0;
    logic        mv_err = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ldma_chan u_ldma_chan (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_start(ext_start),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_snoop(mem_snoop),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mv_go(mv_go),
        .mv_count(mv_count), .mv_src(mv_src), .mv_dst(mv_dst),
        .mv_done(mv_done), .mv_err(mv_err), .irq(irq)
    );

    // memory model: one word per two cycles, answered on the falling edge
    logic [31:0] mem [64];
    int req_cycles = 0;
    int snoop_miss = 0;
    always @(negedge clk) begin
        if (rst) begin
            mem_ack = 1'b0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            mem_ack   = 1'b1;
            mem_rdata = (mem_addr[31:8] == 24'd0) ? mem[mem_addr[7:2]] : 32'hBAD0_0000;
        end
        if (!rst && mem_req) begin
            req_cycles++;
            if (!mem_snoop) snoop_miss++;
        end
    end

    // data mover model
    int mv_delay = 3;
    int mv_left = 0;
    int launches = 0;
    int err_at = 0;
    logic [31:0] log_cnt [8];
    logic [31:0] log_src [8];
    logic [31:0] log_dst [8];
    always @(negedge clk) begin
        mv_done = 1'b0;
        mv_err  = 1'b0;
        if (!rst && mv_go) begin
            if (launches < 8) begin
                log_cnt[launches] = mv_count;
                log_src[launches] = mv_src;
                log_dst[launches] = mv_dst;
            end
            launches++;
            mv_left = mv_delay;
        end else if (mv_left > 0) begin
            mv_left--;
            if (mv_left == 0) begin
                if (launches == err_at) mv_err = 1'b1;
                else mv_done = 1'b1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] link_addr(input int k);
        return 32'h40 + 32'h20 * k;
    endfunction

    function automatic logic [31:0] link_word(input int k, input int n, input logic [3:0] seg);
        return link_addr(k + 1) | ((k == n - 1) ? 32'h1 : 32'h0) | (seg[k] ? 32'h2 : 32'h0) | 32'h4;
    endfunction

    task automatic load_chain(input int v, input int n, input logic [3:0] seg);
        for (int i = 0; i < 64; i++) mem[i] = '0;
        for (int k = 0; k < n; k++) begin
            mem[link_addr(k) >> 2]       = 32'h10 * (k + 1) + v;
            mem[(link_addr(k) >> 2) + 1] = 32'h1000 + 32'h100 * k;
            mem[(link_addr(k) >> 2) + 2] = 32'h2000 + 32'h100 * k + v;
            mem[(link_addr(k) >> 2) + 3] = link_word(k, n, seg);
        end
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 400; i++) begin
            rd(2'd1, s);
            if (!s[3]) break;
        end
    endtask

    task automatic run_chain(input int v, input int n, input logic [3:0] seg,
                             input int e, input logic ext, input logic [31:0] ie);
        logic [31:0] s;
        err_at = e;
        launches = 0;
        load_chain(v, n, seg);
        wr(2'd1, 32'h7);
        wr(2'd0, 32'h0);
        wr(2'd2, link_addr(0) | 32'h4);
        req_cycles = 0;
        wr(2'd0, ie | 32'h1 | (ext ? 32'h4 : 32'h0));
        if (ext) begin
            repeat (6) @(negedge clk);
            rd(2'd1, s);
            chk("R10 busy while waiting for pin", {31'd0, s[3]}, 32'd1);
            chk("R10 no fetch before pin", req_cycles, 32'd0);
            @(negedge clk); ext_start = 1'b1;
            @(negedge clk); ext_start = 1'b0;
        end
        wait_idle();
    endtask

    typedef struct packed {
        logic [3:0] n;
        logic [3:0] seg;
        logic [3:0] err_at;
        logic       ext;
        logic [3:0] exp_go;
        logic [7:0] exp_stat;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{4'd1, 4'h0, 4'd0, 1'b0, 4'd1, 8'h04},
        '{4'd3, 4'h2, 4'd0, 1'b0, 4'd3, 8'h06},
        '{4'd4, 4'hF, 4'd0, 1'b0, 4'd4, 8'h06},
        '{4'd3, 4'h1, 4'd2, 1'b0, 4'd2, 8'h13},
        '{4'd2, 4'h0, 4'd1, 1'b0, 4'd1, 8'h11},
        '{4'd2, 4'h2, 4'd0, 1'b1, 4'd2, 8'h06}
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] s;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd1, s); chk("R1 status after reset", s, 32'h0);
        rd(2'd0, s); chk("R1 control after reset", s, 32'h0);
        rd(2'd2, s); chk("R1 current link after reset", s, 32'h0);
        chk("R1 irq/mem_req/mv_go low", {29'd0, irq, mem_req, mv_go}, 32'h0);

        // table of chains
        for (int v = 0; v < 6; v++) begin
            vec_t t;
            int last;
            t = VECS[v];
            run_chain(v, int'(t.n), t.seg, int'(t.err_at), t.ext, 32'h38);
            last = (t.err_at != 0) ? int'(t.err_at) - 1 : int'(t.n) - 1;
            chk("R3 R4 R7 launch count", launches, {28'd0, t.exp_go});
            for (int k = 0; k < int'(t.exp_go); k++) begin
                chk("R2 R3 mover count", log_cnt[k], 32'h10 * (k + 1) + v);
                chk("R2 R3 mover source", log_src[k], 32'h1000 + 32'h100 * k);
                chk("R2 R3 mover destination", log_dst[k], 32'h2000 + 32'h100 * k + v);
            end
            rd(2'd1, s); chk("R5 R6 R7 status", s, {24'd0, t.exp_stat});
            chk("R4 snoop on every fetch", snoop_miss, 32'd0);
            rd(2'd2, s);
            chk("R4 current link", s, (last == 0) ? (link_addr(0) | 32'h4) : link_word(last - 1, int'(t.n), t.seg));
            rd(2'd3, s); chk("R4 next link", s, link_word(last, int'(t.n), t.seg));
            chk("R12 irq with all enables", {31'd0, irq}, 32'd1);
        end

        // R8 write-one-to-clear
        run_chain(7, 3, 4'h1, 2, 1'b0, 32'h38);
        rd(2'd1, s); chk("R8 status before clear", s, 32'h13);
        wr(2'd1, 32'h02); rd(2'd1, s); chk("R8 clear segment bit only", s, 32'h11);
        wr(2'd1, 32'h00); rd(2'd1, s); chk("R8 zero write keeps bits", s, 32'h11);
        wr(2'd1, 32'h1F); rd(2'd1, s); chk("R8 halted not clearable", s, 32'h10);

        // R12 enables gate the interrupt
        run_chain(8, 1, 4'h0, 0, 1'b0, 32'h08);
        chk("R12 end of chain masked", {31'd0, irq}, 32'd0);
        wr(2'd0, 32'h20);
        chk("R12 end of chain enabled", {31'd0, irq}, 32'd1);
        rd(2'd0, s); chk("R12 control readback", s, 32'h20);

        // R9 abort and R13 ignored current-link write
        mv_delay = 20;
        err_at = 0;
        launches = 0;
        load_chain(9, 3, 4'h0);
        wr(2'd1, 32'h7);
        wr(2'd0, 32'h0);
        wr(2'd2, link_addr(0) | 32'h4);
        wr(2'd0, 32'h1);
        for (int i = 0; i < 100 && launches == 0; i++) @(negedge clk);
        wr(2'd2, 32'h80);
        rd(2'd1, s); chk("R9 busy before abort", s, 32'h08);
        wr(2'd0, 32'h2);
        repeat (30) @(negedge clk);
        chk("R9 no launch after abort", launches, 32'd1);
        rd(2'd1, s); chk("R9 halted after abort", s, 32'h10);
        rd(2'd2, s); chk("R13 write while busy ignored", s, link_addr(0) | 32'h4);
        mv_delay = 3;

        // R11 zero control write
        wr(2'd0, 32'h0);
        rd(2'd1, s); chk("R11 status cleared", s, 32'h0);
        rd(2'd0, s); chk("R11 control cleared", s, 32'h0);
        chk("R11 irq low", {31'd0, irq}, 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule